// File: doc/BRIEF.md
# Transmit Packet Progress Tracker

This block follows the progress of a bus-master transmit engine that moves fixed-size packets, either one at a time or back to back in a continuous mode. The engine reports each completed data beat with its byte count, and signals the end of every packet as either a normal or an abnormal termination. The tracker keeps two counters: the bytes sent in the current packet and, in continuous mode, the packets already sent. It also holds a sticky normal-termination flag that can raise an interrupt.

Software reaches the counters, the status flag and the interrupt enable through a small register port. Reads are combinational and writes take effect on the next clock edge. The status flag is write-one-to-clear. The packet counter clears on a controller restart. It also clears when the master enable drops during a transfer and stays low until the packet ends normally. That clear does not disturb the restart of the byte count in continuous mode. While the packet size stays constant and no clear has happened, `packets × size + bytes` gives the total sent since the last restart.

Top module: `tx_progress_tracker`

## Requirements
- R1: Each cycle with `beat_done` high adds `beat_bytes` to the bytes counter, modulo 2^16. The progress register (address 0) shows the bytes counter in bits 31:16 and the packets counter in bits 15:0.
- R2: The engine ends a packet only when the bytes counter equals `pkt_size`. With `cont_mode` low, a normal termination leaves both counters unchanged.
- R3: With `cont_mode` high, a normal termination sets the bytes counter to 0 and adds one to the packets counter on the next edge.
- R4: With `cont_mode` low, the packets counter holds its value through terminations. The clears of R5 and R6 still apply.
- R5: A `ctrl_restart` pulse clears both counters on the next edge. It takes priority over every other update.
- R6: The packets counter clears on a normal termination when `master_en` went low while a transfer was in progress and stayed low until that termination. If `master_en` returns high first, nothing is cleared. In either case the bytes counter follows R3.
- R7: A normal termination sets the status flag (address 1, bit 24). An abnormal termination (`term_err`) leaves it unchanged.
- R8: Writing 1 to bit 24 at address 1 clears the flag. Writing 0 there, or writing to a flag that is already clear, has no effect. A termination in the same cycle as a clearing write leaves the flag set.
- R9: `irq` is high exactly while the status flag is set and the enable bit (address 2, bit 0, read/write) is set.
- R10: After reset every register reads 0 and `irq` is low. All status bits other than bit 24 always read 0.
- R11: While `pkt_size` is constant and no clear has occurred since a restart, `packets × pkt_size + bytes` equals the bytes reported since that restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| beat_done | input | 1 | A data beat completed successfully |
| beat_bytes | input | 8 | Bytes carried by that beat |
| pkt_size | input | 16 | Programmed packet size in bytes |
| cont_mode | input | 1 | Continuous mode active |
| ctrl_restart | input | 1 | Controller restart pulse |
| master_en | input | 1 | Master enable level |
| term_ok | input | 1 | Packet ended normally |
| term_err | input | 1 | Packet ended abnormally |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 progress, 1 status, 2 control |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
Every counter and flag sits one register away from its input. An event driven before an edge appears in the register reads shortly after that edge. `irq` and `reg_rdata` are combinational from those registers, so they change in the same cycle as the flag and need no extra wait. The bench drives inputs at the falling edge and steps its model with the same inputs before the rising edge. It compares every readable field and `irq` one time unit after that edge, stepping `reg_addr` through the three registers before the next falling edge. Random continuous-mode traffic with random clearing writes is combined with directed cases: counter wrap, same-cycle set and clear, and both outcomes of the enable drop.

// File: rtl/tx_trk_pkg.sv
// Package: shared register addresses and bit positions of the tracker.
package tx_trk_pkg;
    typedef enum logic [1:0] {
        ADDR_PROG = 2'd0,
        ADDR_STAT = 2'd1,
        ADDR_CTRL = 2'd2
    } trk_addr_e;

    localparam int NT_BIT  = 24;  // normal-termination flag in the status word
    localparam int IEN_BIT = 0;   // interrupt enable in the control word
endpackage

// File: rtl/trk_byte_counter.sv
// Bytes-done counter. Adds each beat's byte count, clears on restart and on
// the packet boundary in continuous mode. Assumes BEAT_W <= CNT_W.
module trk_byte_counter #(
    parameter int CNT_W  = 16,
    parameter int BEAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_done,
    input  logic [BEAT_W-1:0] beat_bytes,
    input  logic              ctrl_restart,
    input  logic              wrap_pkt,
    output logic [CNT_W-1:0]  bytes_done
);
    // Next count: restart, packet wrap, beat accumulation, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bytes_done <= '0;
        else if (ctrl_restart || wrap_pkt)
            bytes_done <= '0;
        else if (beat_done)
            bytes_done <= bytes_done + CNT_W'(beat_bytes);
    end
endmodule

// File: rtl/trk_packet_counter.sv
// Packets-done counter with its clear rules. It tracks whether a transfer
// is in flight and whether master enable dropped during it. Assumes the
// termination pulses are single-cycle.
module trk_packet_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_done,
    input  logic             term_ok,
    input  logic             term_err,
    input  logic             cont_mode,
    input  logic             ctrl_restart,
    input  logic             master_en,
    output logic [CNT_W-1:0] pkts_done
);
    logic in_flight;
    logic drop_armed;
    logic drop_now;

    // Enable is low and was low since a transfer was in progress.
    assign drop_now = !master_en && (drop_armed || in_flight);

    // Transfer in flight: from the first beat to any end of packet.
    always_ff @(posedge clk) begin
        if (!rst_n)
            in_flight <= 1'b0;
        else if (ctrl_restart || term_ok || term_err)
            in_flight <= 1'b0;
        else if (beat_done)
            in_flight <= 1'b1;
    end

    // Remember an enable drop until the packet ends or the enable returns.
    always_ff @(posedge clk) begin
        if (!rst_n)
            drop_armed <= 1'b0;
        else
            drop_armed <= drop_now && !term_ok && !term_err && !ctrl_restart;
    end

    // Packet count: restart, enable-drop clear, continuous increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pkts_done <= '0;
        else if (ctrl_restart)
            pkts_done <= '0;
        else if (term_ok && drop_now)
            pkts_done <= '0;
        else if (term_ok && cont_mode)
            pkts_done <= pkts_done + 1'b1;
    end
endmodule

// File: rtl/trk_status_reg.sv
// Sticky normal-termination flag with write-one-to-clear, the interrupt
// enable bit and the interrupt output. A hardware set beats a clear.
module trk_status_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic set_nt,
    input  logic clr_nt,
    input  logic ien_we,
    input  logic ien_wdata,
    output logic nt,
    output logic ien,
    output logic irq
);
    // Flag: set has priority over the software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            nt <= 1'b0;
        else if (set_nt)
            nt <= 1'b1;
        else if (clr_nt)
            nt <= 1'b0;
    end

    // Interrupt enable: plain read/write bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ien <= 1'b0;
        else if (ien_we)
            ien <= ien_wdata;
    end

    assign irq = nt && ien;
endmodule

// File: rtl/tx_progress_tracker.sv
// Top: transmit packet progress and status tracker. Wires the counters and
// the status register, decodes register writes and muxes read data.
// Assumes DATA_W is even and wider than the flag position.
module tx_progress_tracker #(
    parameter int DATA_W = 32,
    parameter int BEAT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 beat_done,
    input  logic [BEAT_W-1:0]    beat_bytes,
    input  logic [DATA_W/2-1:0]  pkt_size,
    input  logic                 cont_mode,
    input  logic                 ctrl_restart,
    input  logic                 master_en,
    input  logic                 term_ok,
    input  logic                 term_err,
    input  logic                 reg_wr,
    input  logic [1:0]           reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 irq
);
    import tx_trk_pkg::*;

    localparam int CNT_W = DATA_W / 2;

    logic [CNT_W-1:0] bytes_done;
    logic [CNT_W-1:0] pkts_done;
    logic             nt;
    logic             ien;
    logic             wr_stat;
    logic             wr_ctrl;
    logic             sig_unused;

    assign wr_stat    = reg_wr && (reg_addr == ADDR_STAT);
    assign wr_ctrl    = reg_wr && (reg_addr == ADDR_CTRL);
    assign sig_unused = ^{reg_wdata, pkt_size};

    trk_byte_counter #(.CNT_W(CNT_W), .BEAT_W(BEAT_W)) u_bytes (
        .clk          (clk),
        .rst_n        (rst_n),
        .beat_done    (beat_done),
        .beat_bytes   (beat_bytes),
        .ctrl_restart (ctrl_restart),
        .wrap_pkt     (term_ok && cont_mode),
        .bytes_done   (bytes_done)
    );

    trk_packet_counter #(.CNT_W(CNT_W)) u_pkts (
        .clk          (clk),
        .rst_n        (rst_n),
        .beat_done    (beat_done),
        .term_ok      (term_ok),
        .term_err     (term_err),
        .cont_mode    (cont_mode),
        .ctrl_restart (ctrl_restart),
        .master_en    (master_en),
        .pkts_done    (pkts_done)
    );

    trk_status_reg u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_nt    (term_ok),
        .clr_nt    (wr_stat && reg_wdata[NT_BIT]),
        .ien_we    (wr_ctrl),
        .ien_wdata (reg_wdata[IEN_BIT]),
        .nt        (nt),
        .ien       (ien),
        .irq       (irq)
    );

    // Read mux: progress, status and control words; others read 0.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_PROG: reg_rdata = {bytes_done, pkts_done};
            ADDR_STAT: reg_rdata[NT_BIT]  = nt;
            ADDR_CTRL: reg_rdata[IEN_BIT] = ien;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tx_trk_checker.sv
// Checker: temporal properties of the tracker, bound to the top module.
module tx_trk_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             beat_done,
    input logic             term_ok,
    input logic             cont_mode,
    input logic             ctrl_restart,
    input logic             master_en,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic             wdata_nt,
    input logic [CNT_W-1:0] pkt_size,
    input logic [CNT_W-1:0] bytes_done,
    input logic [CNT_W-1:0] pkts_done,
    input logic             nt
);
    // R2: a packet ends only with the full size counted
    p_size_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        term_ok |-> bytes_done == pkt_size);

    // R2: single-mode termination keeps the byte count
    p_single_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (term_ok && !cont_mode && !ctrl_restart && !beat_done)
        |=> bytes_done == $past(bytes_done));

    // R3: continuous-mode termination restarts the byte count
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (term_ok && cont_mode && !ctrl_restart) |=> bytes_done == '0);

    // R4: outside continuous mode with enable high the packet count holds
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cont_mode && !ctrl_restart && master_en) |=> $stable(pkts_done));

    // R5: restart clears both counters
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_restart |=> (bytes_done == '0 && pkts_done == '0));

    // R7: normal termination sets the flag
    p_nt_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        term_ok |=> nt);

    // R7: the flag never rises without a normal termination
    p_nt_only_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!nt && !term_ok) |=> !nt);

    // R8: a set flag stays set unless software writes a one to it
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (nt && !(reg_wr && reg_addr == 2'd1 && wdata_nt)) |=> nt);
endmodule

bind tx_progress_tracker tx_trk_checker #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .beat_done    (beat_done),
    .term_ok      (term_ok),
    .cont_mode    (cont_mode),
    .ctrl_restart (ctrl_restart),
    .master_en    (master_en),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .wdata_nt     (reg_wdata[24]),
    .pkt_size     (pkt_size),
    .bytes_done   (bytes_done),
    .pkts_done    (pkts_done),
    .nt           (nt)
);

// File: tb/tx_progress_tracker_tb.sv
// Bench: random continuous traffic plus directed corners against a model.
module tx_progress_tracker_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        beat_done = 1'b0;
    logic [7:0]  beat_bytes = '0;
    logic [15:0] pkt_size = '0;
    logic        cont_mode = 1'b0;
    logic        ctrl_restart = 1'b0;
    logic        master_en = 1'b1;
    logic        term_ok = 1'b0;
    logic        term_err = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // Model state
    logic [15:0] m_bytes = '0, m_pkts = '0;
    bit m_nt = 0, m_en = 0, m_busy = 0, m_arm = 0;
    int unsigned ref_sent = 0;

    tx_progress_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .beat_done(beat_done), .beat_bytes(beat_bytes),
        .pkt_size(pkt_size), .cont_mode(cont_mode), .ctrl_restart(ctrl_restart),
        .master_en(master_en), .term_ok(term_ok), .term_err(term_err),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_prog();
        return {m_bytes, m_pkts};
    endfunction

    function automatic logic [31:0] exp_stat();
        return {7'b0, m_nt, 24'b0};
    endfunction

    // One model step from the inputs currently driven
    task automatic model_step();
        bit drop;
        drop = !master_en && (m_arm || m_busy);
        if (ctrl_restart) ref_sent = 0;
        else if (beat_done) ref_sent += beat_bytes;
        if (ctrl_restart) m_pkts = '0;
        else if (term_ok && drop) m_pkts = '0;
        else if (term_ok && cont_mode) m_pkts = m_pkts + 16'd1;
        if (ctrl_restart || (term_ok && cont_mode)) m_bytes = '0;
        else if (beat_done) m_bytes = m_bytes + 16'(beat_bytes);
        m_arm = drop && !term_ok && !term_err && !ctrl_restart;
        if (ctrl_restart || term_ok || term_err) m_busy = 0;
        else if (beat_done) m_busy = 1;
        if (term_ok) m_nt = 1;
        else if (reg_wr && reg_addr == 2'd1 && reg_wdata[24]) m_nt = 0;
        if (reg_wr && reg_addr == 2'd2) m_en = reg_wdata[0];
    endtask

    // Compare all readable state and the interrupt
    task automatic check_all();
        reg_addr = 2'd0; #1;
        chk(reg_rdata, exp_prog(), "R1/R3 progress");
        reg_addr = 2'd1; #1;
        chk(reg_rdata, exp_stat(), "R7/R10 status");
        reg_addr = 2'd2; #1;
        chk(reg_rdata, {31'b0, m_en}, "R9 control");
        chk({31'b0, irq}, {31'b0, m_nt && m_en}, "R9 irq");
    endtask

    // Advance one clock with the driven inputs, then release pulses and check
    task automatic tick();
        model_step();
        @(posedge clk); #1;
        beat_done = 0; term_ok = 0; term_err = 0; ctrl_restart = 0; reg_wr = 0;
        check_all();
        @(negedge clk);
    endtask

    task automatic beat(input int n);
        beat_done = 1; beat_bytes = 8'(n); tick();
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d; tick();
    endtask

    task automatic send_pkt(input int size, input bit rnd_clr);
        int remain;
        remain = size;
        while (remain > 0) begin
            int b;
            b = 1 + int'($urandom % 8);
            if (b > remain) b = remain;
            beat(b);
            remain -= b;
            if ($urandom % 4 == 0) tick();
            if (rnd_clr && $urandom % 5 == 0) wr(2'd1, 32'h0100_0000);
            if (cont_mode && rnd_clr)
                chk(32'(m_pkts) * 32'(pkt_size) + 32'(m_bytes), ref_sent, "R11 identity");
        end
        term_ok = 1; tick();
    endtask

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        @(negedge clk);
        check_all();                              // R10 reset values
        chk({31'b0, irq}, 32'd0, "R10 irq at reset");
        rst_n = 1; @(negedge clk);

        wr(2'd2, 32'h1);                          // R9 enable on
        chk({31'b0, m_en}, 32'd1, "R9 enable model");

        // R2: single packet, counters hold at termination
        pkt_size = 16'd20;
        send_pkt(20, 0);
        reg_addr = 2'd0; #1;
        chk(reg_rdata, {16'd20, 16'd0}, "R2 bytes equal size");
        chk({31'b0, irq}, 32'd1, "R9 irq after normal end");
        @(negedge clk);

        // R8: write 0 no effect, write 1 clears, write 1 on clear flag stays clear
        wr(2'd1, 32'h0);
        reg_addr = 2'd1; #1; chk(reg_rdata, 32'h0100_0000, "R8 write zero ignored");
        @(negedge clk);
        wr(2'd1, 32'hFFFF_FFFF);
        reg_addr = 2'd1; #1; chk(reg_rdata, 32'h0, "R8 write one clears");
        @(negedge clk);
        wr(2'd1, 32'h0100_0000);
        reg_addr = 2'd1; #1; chk(reg_rdata, 32'h0, "R8 stays clear");
        @(negedge clk);

        // R7: abnormal end does not set the flag
        ctrl_restart = 1; tick();
        beat(5); term_err = 1; tick();
        reg_addr = 2'd1; #1; chk(reg_rdata, 32'h0, "R7 abnormal no flag");
        @(negedge clk);

        // R8: set and clear in the same cycle, set wins
        ctrl_restart = 1; tick();
        pkt_size = 16'd3; beat(3);
        term_ok = 1; reg_wr = 1; reg_addr = 2'd1; reg_wdata = 32'h0100_0000; tick();
        reg_addr = 2'd1; #1; chk(reg_rdata, 32'h0100_0000, "R8 set beats clear");
        @(negedge clk);

        // R3/R11: random continuous traffic
        ctrl_restart = 1; tick();
        cont_mode = 1; pkt_size = 16'd37;
        for (int p = 0; p < 25; p++) send_pkt(37, 1);
        chk(32'(m_pkts), 32'd25, "R3 packets counted");
        reg_addr = 2'd0; #1; chk(reg_rdata, {16'd0, 16'd25}, "R3 bytes restart");
        @(negedge clk);

        // R4: leaving continuous mode holds the packet count
        cont_mode = 0; pkt_size = 16'd9;
        beat(4); beat(5); term_ok = 1; tick();
        reg_addr = 2'd0; #1; chk(reg_rdata, {16'd9, 16'd25}, "R4 packets hold");
        @(negedge clk);

        // R6: enable drop during transfer held to termination clears packets
        ctrl_restart = 1; tick();
        cont_mode = 1; pkt_size = 16'd6;
        send_pkt(6, 0); send_pkt(6, 0);
        beat(6); master_en = 0; tick(); tick();
        term_ok = 1; tick();
        reg_addr = 2'd0; #1; chk(reg_rdata, 32'h0, "R6 drop clears packets");
        @(negedge clk);
        master_en = 1;

        // R6: enable back before termination, no clear
        send_pkt(6, 0);
        beat(6); master_en = 0; tick(); master_en = 1; tick();
        term_ok = 1; tick();
        reg_addr = 2'd0; #1; chk(reg_rdata, {16'd0, 16'd2}, "R6 recovered enable");
        @(negedge clk);

        // R5: restart clears counters
        beat(2); ctrl_restart = 1; beat_done = 1; tick();
        reg_addr = 2'd0; #1; chk(reg_rdata, 32'h0, "R5 restart clears");
        @(negedge clk);

        // R1: accumulation wraps modulo 2^16
        cont_mode = 0;
        for (int i = 0; i < 260; i++) begin
            beat_done = 1; beat_bytes = 8'd255; tick();
        end
        reg_addr = 2'd0; #1;
        chk(reg_rdata, {16'((260 * 255) % 65536), 16'd0}, "R1 byte wrap");
        @(negedge clk);
        ctrl_restart = 1; tick();

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule